// File: doc/BRIEF.md
# AHB-Lite to APB Protocol Bridge

This block sits on an AHB-Lite bus as a slave and turns each accepted transfer into one APB access for a small group of register-mapped peripherals. Both sides run on the same clock. Every beat of a single, incrementing or wrapping burst becomes its own APB access. The bridge holds the AHB master with its ready output while that access runs through a setup cycle and an enable cycle.

The captured address is decoded into one select line per peripheral. Peripheral `i` owns a window of `2**REGION_LSB` bytes at `BASE_ADDR + i * 2**REGION_LSB`. An address outside every window selects nothing. It still takes the same two APB cycles, and a read from it returns zero. The bridge is the only APB master, so it needs no arbitration. It never raises an error response.

Top module: `ahb_apb_bridge`

## Requirements
- R1: While `rst_n` is low, `apb_sel` is all zero, `apb_enable` is low and `ahb_ready_out` is high.
- R2: No APB access starts unless, at a rising edge, `ahb_sel`, `ahb_ready_in` and `ahb_ready_out` are all high and `ahb_trans` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) are answered with `ahb_ready_out` high and leave `apb_sel` and `apb_enable` low.
- R3: An accepted beat gives exactly one setup cycle (select high, `apb_enable` low) followed by exactly one enable cycle (`apb_enable` high). After that, the bus returns to idle unless another beat was accepted.
- R4: `ahb_ready_out` is low in the setup cycle that follows acceptance and high in the enable cycle, so the master waits exactly one cycle per beat.
- R5: `apb_addr` and `apb_write` equal the `ahb_addr` and `ahb_write` captured at acceptance, and they hold steady through the enable cycle.
- R6: `apb_wdata` carries the `ahb_wdata` that the master drives in the data phase, in both the setup cycle and the enable cycle.
- R7: With the default parameters, peripheral `i` (bit `i` of `apb_sel`, i = 0..2) is selected when `addr[31:14]` is 18'h08000 and `addr[13:12]` is `i`. Every other address selects nothing. At most one select bit is ever high, and the select holds from setup into enable.
- R8: In the enable cycle of a read, `ahb_rdata` equals `apb_rdata` when a peripheral is selected, and is zero when none is selected.
- R9: A beat accepted during the enable cycle of the previous beat starts its setup cycle in the very next cycle, with no idle cycle between them. This is how burst beats run back to back.
- R10: `ahb_resp` is always OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both buses |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahb_sel | input | 1 | Slave select from the AHB decoder |
| ahb_addr | input | ADDR_W | Address-phase address |
| ahb_trans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| ahb_write | input | 1 | Address-phase direction, 1 = write |
| ahb_ready_in | input | 1 | Bus-wide ready seen by all slaves |
| ahb_wdata | input | DATA_W | Data-phase write data |
| ahb_rdata | output | DATA_W | Read data returned to the master |
| ahb_ready_out | output | 1 | This slave's ready; low stalls the master |
| ahb_resp | output | 1 | Response, always OKAY |
| apb_addr | output | ADDR_W | APB address |
| apb_write | output | 1 | APB direction |
| apb_wdata | output | DATA_W | APB write data |
| apb_enable | output | 1 | High in the enable cycle |
| apb_sel | output | PERIPH_CNT | One-hot peripheral selects |
| apb_rdata | input | DATA_W | Read data from the selected peripheral |

## Verification
The bench sweeps single transfers in both directions across every peripheral window, across the unused window index and across an address outside the base. A decoder with a wrong window comparison would raise the wrong select bit, and a bridge that skipped the timing for unmatched addresses would stop stalling for them. Back-to-back incrementing and wrapping bursts check that each next beat, held on the bus while the bridge stalls, is taken only once the enable cycle arrives. A bridge that gated acceptance wrongly would either drop beats or insert an idle gap. Probes with BUSY, IDLE, the select low and a foreign wait state check that none of these starts an access. Unmatched reads are run against a peripheral model that drives all ones, so a bridge that passed `apb_rdata` through without gating would return nonzero data.

// File: rtl/apbr_pkg.sv
package apbr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_SETUP  = 2'b01,
      ST_ENABLE = 2'b10
   } apbr_state_e;

   localparam logic [1:0] TR_IDLE   = 2'b00;
   localparam logic [1:0] TR_BUSY   = 2'b01;
   localparam logic [1:0] TR_NONSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ    = 2'b11;

   localparam logic RESP_OKAY = 1'b0;

   function automatic logic trans_starts_beat(input logic [1:0] t);
      return (t == TR_NONSEQ) || (t == TR_SEQ);
   endfunction

endpackage

// File: rtl/apbr_addr_decode.sv
module apbr_addr_decode #(
   parameter int unsigned HI_W       = 18,
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned PERIPH_CNT = 3,
   parameter logic [HI_W-1:0] MATCH_HI = '0
) (
   input  logic [HI_W+IDX_W-1:0] addr_top,
   output logic [PERIPH_CNT-1:0] sel_vec
);
   logic             base_hit;
   logic [IDX_W-1:0] win_idx;

   assign base_hit = (addr_top[HI_W+IDX_W-1 -: HI_W] == MATCH_HI);
   assign win_idx  = addr_top[IDX_W-1:0];

   for (genvar gi = 0; gi < PERIPH_CNT; gi++) begin : g_win
      assign sel_vec[gi] = base_hit && (win_idx == IDX_W'(gi));
   end
endmodule

// File: rtl/apbr_seq.sv
module apbr_seq
   import apbr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        beat_req,
   output apbr_state_e state,
   output logic        accept,
   output logic        ready_out,
   output logic        enable
);
   apbr_state_e state_q, state_d;

   assign accept = beat_req && (state_q != ST_SETUP);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   state_d = accept ? ST_SETUP : ST_IDLE;
         ST_SETUP:  state_d = ST_ENABLE;
         ST_ENABLE: state_d = accept ? ST_SETUP : ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state     = state_q;
   assign ready_out = (state_q != ST_SETUP);
   assign enable    = (state_q == ST_ENABLE);
endmodule

// File: rtl/apbr_xfer_regs.sv
module apbr_xfer_regs
   import apbr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PERIPH_CNT = 3,
   parameter bit          HOLD_WDATA = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  apbr_state_e           state,
   input  logic [ADDR_W-1:0]     addr_in,
   input  logic                  write_in,
   input  logic [DATA_W-1:0]     wdata_in,
   input  logic [PERIPH_CNT-1:0] sel_dec,
   input  logic [DATA_W-1:0]     prdata,
   output logic [ADDR_W-1:0]     paddr,
   output logic                  pwrite,
   output logic [DATA_W-1:0]     pwdata,
   output logic [PERIPH_CNT-1:0] psel,
   output logic [DATA_W-1:0]     rdata_out
);
   logic [ADDR_W-1:0]     addr_q;
   logic                  write_q;
   logic [PERIPH_CNT-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         write_q <= 1'b0;
         sel_q   <= '0;
      end else if (accept) begin
         addr_q  <= addr_in;
         write_q <= write_in;
         sel_q   <= sel_dec;
      end else if (state == ST_ENABLE) begin
         sel_q   <= '0;
      end
   end

   if (HOLD_WDATA) begin : g_wdata_held
      logic [DATA_W-1:0] wdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 wdata_q <= '0;
         else if (state == ST_SETUP) wdata_q <= wdata_in;
      end
      assign pwdata = (state == ST_SETUP) ? wdata_in : wdata_q;
   end else begin : g_wdata_pass
      assign pwdata = wdata_in;
   end

   assign paddr     = addr_q;
   assign pwrite    = write_q;
   assign psel      = sel_q;
   assign rdata_out = ((state == ST_ENABLE) && !write_q && (|sel_q)) ? prdata : '0;
endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
   import apbr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PERIPH_CNT = 3,
   parameter int unsigned REGION_LSB = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000,
   parameter bit          HOLD_WDATA = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ahb_sel,
   input  logic [ADDR_W-1:0]     ahb_addr,
   input  logic [1:0]            ahb_trans,
   input  logic                  ahb_write,
   input  logic                  ahb_ready_in,
   input  logic [DATA_W-1:0]     ahb_wdata,
   output logic [DATA_W-1:0]     ahb_rdata,
   output logic                  ahb_ready_out,
   output logic                  ahb_resp,
   output logic [ADDR_W-1:0]     apb_addr,
   output logic                  apb_write,
   output logic [DATA_W-1:0]     apb_wdata,
   output logic                  apb_enable,
   output logic [PERIPH_CNT-1:0] apb_sel,
   input  logic [DATA_W-1:0]     apb_rdata
);
   localparam int unsigned IDX_W = (PERIPH_CNT > 1) ? $clog2(PERIPH_CNT) : 1;
   localparam int unsigned TOP_W = ADDR_W - REGION_LSB;
   localparam int unsigned HI_W  = TOP_W - IDX_W;
   localparam logic [HI_W-1:0] MATCH_HI = BASE_ADDR[ADDR_W-1 -: HI_W];

   if (PERIPH_CNT < 1) begin : g_bad_cnt
      $error("PERIPH_CNT must be at least 1");
   end
   if (REGION_LSB + IDX_W >= ADDR_W) begin : g_bad_region
      $error("peripheral windows do not fit in ADDR_W");
   end
   if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 8, 16 or 32");
   end
   if (BASE_ADDR[REGION_LSB+IDX_W-1:0] != '0) begin : g_bad_base
      $error("BASE_ADDR must be aligned to the full window span");
   end

   apbr_state_e           state;
   logic                  beat_req;
   logic                  accept;
   logic [PERIPH_CNT-1:0] sel_dec;

   assign beat_req = ahb_sel && ahb_ready_in && trans_starts_beat(ahb_trans);

   apbr_addr_decode #(
      .HI_W       (HI_W),
      .IDX_W      (IDX_W),
      .PERIPH_CNT (PERIPH_CNT),
      .MATCH_HI   (MATCH_HI)
   ) u_decode (
      .addr_top (ahb_addr[ADDR_W-1:REGION_LSB]),
      .sel_vec  (sel_dec)
   );

   apbr_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_req  (beat_req),
      .state     (state),
      .accept    (accept),
      .ready_out (ahb_ready_out),
      .enable    (apb_enable)
   );

   apbr_xfer_regs #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PERIPH_CNT (PERIPH_CNT),
      .HOLD_WDATA (HOLD_WDATA)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .state     (state),
      .addr_in   (ahb_addr),
      .write_in  (ahb_write),
      .wdata_in  (ahb_wdata),
      .sel_dec   (sel_dec),
      .prdata    (apb_rdata),
      .paddr     (apb_addr),
      .pwrite    (apb_write),
      .pwdata    (apb_wdata),
      .psel      (apb_sel),
      .rdata_out (ahb_rdata)
   );

   assign ahb_resp = RESP_OKAY;
endmodule

// File: rtl/apbr_checker.sv
module apbr_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PERIPH_CNT = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ahb_sel,
   input logic [1:0]            ahb_trans,
   input logic                  ahb_ready_in,
   input logic                  ahb_ready_out,
   input logic [DATA_W-1:0]     ahb_rdata,
   input logic [ADDR_W-1:0]     apb_addr,
   input logic                  apb_write,
   input logic                  apb_enable,
   input logic [PERIPH_CNT-1:0] apb_sel,
   input logic [DATA_W-1:0]     apb_rdata
);
   logic req, take;
   assign req  = ahb_sel && ahb_ready_in && ahb_trans[1];
   assign take = req && ahb_ready_out;

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_r1: assert (apb_sel == '0 && !apb_enable && ahb_ready_out)
            else $error("reset state wrong");
      end
   end

   p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ahb_ready_out && !req) |=> (ahb_ready_out && !apb_enable && apb_sel == '0));

   p_setup_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!apb_enable ##1 apb_enable));

   p_enable_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      apb_enable |=> !apb_enable);

   p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ahb_ready_out);

   p_stall_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ahb_ready_out |=> (ahb_ready_out && apb_enable));

   p_ctrl_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      apb_enable |-> ($stable(apb_addr) && $stable(apb_write)));

   p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(apb_sel));

   p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ahb_ready_out |=> $stable(apb_sel));

   p_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (apb_enable && !apb_write && apb_sel != '0) |-> (ahb_rdata == apb_rdata));

   p_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (apb_enable && apb_sel == '0) |-> (ahb_rdata == '0));
endmodule

bind ahb_apb_bridge apbr_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .PERIPH_CNT (PERIPH_CNT)
) u_apbr_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .ahb_sel       (ahb_sel),
   .ahb_trans     (ahb_trans),
   .ahb_ready_in  (ahb_ready_in),
   .ahb_ready_out (ahb_ready_out),
   .ahb_rdata     (ahb_rdata),
   .apb_addr      (apb_addr),
   .apb_write     (apb_write),
   .apb_enable    (apb_enable),
   .apb_sel       (apb_sel),
   .apb_rdata     (apb_rdata)
);

// File: tb/test_ahb_apb_bridge.sv
`timescale 1ns/1ps
module test_ahb_apb_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ahb_sel = 1'b0;
   logic [31:0] ahb_addr = '0;
   logic [1:0]  ahb_trans = 2'b00;
   logic        ahb_write = 1'b0;
   logic        ahb_ready_in;
   logic [31:0] ahb_wdata = '0;
   logic [31:0] ahb_rdata;
   logic        ahb_ready_out;
   logic        ahb_resp;
   logic [31:0] apb_addr;
   logic        apb_write;
   logic [31:0] apb_wdata;
   logic        apb_enable;
   logic [2:0]  apb_sel;
   logic [31:0] apb_rdata;
   logic        ext_wait = 1'b0;

   int vectors = 0;
   int miscompares = 0;
   logic [31:0] beat_addr [16];

   always #4 clk = ~clk;

   assign ahb_ready_in = ahb_ready_out && !ext_wait;
   assign apb_rdata = (apb_sel != '0) ? (apb_addr ^ 32'h5A5A_0000) : 32'hFFFF_FFFF;

   ahb_apb_bridge i_ahb_apb_bridge (
      .clk(clk), .rst_n(rst_n), .ahb_sel(ahb_sel), .ahb_addr(ahb_addr),
      .ahb_trans(ahb_trans), .ahb_write(ahb_write), .ahb_ready_in(ahb_ready_in),
      .ahb_wdata(ahb_wdata), .ahb_rdata(ahb_rdata), .ahb_ready_out(ahb_ready_out),
      .ahb_resp(ahb_resp), .apb_addr(apb_addr), .apb_write(apb_write),
      .apb_wdata(apb_wdata), .apb_enable(apb_enable), .apb_sel(apb_sel),
      .apb_rdata(apb_rdata)
   );

   function automatic logic [2:0] exp_sel(input logic [31:0] a);
      if (a[31:14] == 18'h08000 && a[13:12] != 2'd3) return 3'b001 << a[13:12];
      return 3'b000;
   endfunction

   function automatic logic [31:0] wdat(input logic [31:0] a, input int k);
      return ~a + 32'(k * 7);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_beats(input int n, input logic wr);
      @(negedge clk);
      ahb_sel = 1'b1; ahb_addr = beat_addr[0]; ahb_trans = 2'b10; ahb_write = wr;
      #1 check("R2 ready before first beat", 32'(ahb_ready_out), 32'd1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k + 1 < n) begin
            ahb_addr = beat_addr[k+1]; ahb_trans = 2'b11;
         end else begin
            ahb_sel = 1'b0; ahb_trans = 2'b00;
         end
         ahb_wdata = wdat(beat_addr[k], k);
         #1;
         check(k > 0 ? "R9 setup follows enable" : "R3 setup penable", 32'(apb_enable), 32'd0);
         check("R4 stall in setup", 32'(ahb_ready_out), 32'd0);
         check("R7 select in setup", 32'(apb_sel), 32'(exp_sel(beat_addr[k])));
         check("R5 address", apb_addr, beat_addr[k]);
         check("R5 direction", 32'(apb_write), 32'(wr));
         if (wr) check("R6 wdata in setup", apb_wdata, wdat(beat_addr[k], k));
         @(negedge clk); #1;
         check("R3 enable cycle", 32'(apb_enable), 32'd1);
         check("R4 ready in enable", 32'(ahb_ready_out), 32'd1);
         check("R7 select in enable", 32'(apb_sel), 32'(exp_sel(beat_addr[k])));
         check("R5 address held", apb_addr, beat_addr[k]);
         check("R10 resp okay", 32'(ahb_resp), 32'd0);
         if (wr) check("R6 wdata in enable", apb_wdata, wdat(beat_addr[k], k));
         else if (exp_sel(beat_addr[k]) != 3'b000)
            check("R8 read data", ahb_rdata, beat_addr[k] ^ 32'h5A5A_0000);
         else
            check("R8 unmatched read zero", ahb_rdata, 32'd0);
      end
      @(negedge clk); #1;
      check("R3 idle after last beat penable", 32'(apb_enable), 32'd0);
      check("R3 idle after last beat psel", 32'(apb_sel), 32'd0);
      check("R3 idle ready", 32'(ahb_ready_out), 32'd1);
   endtask

   task automatic probe(input string tag, input logic sel, input logic [1:0] tr, input logic wt);
      @(negedge clk);
      ahb_sel = sel; ahb_trans = tr; ahb_addr = 32'h2000_1000; ext_wait = wt; ahb_write = 1'b1;
      @(negedge clk); #1;
      check({tag, " penable"}, 32'(apb_enable), 32'd0);
      check({tag, " psel"}, 32'(apb_sel), 32'd0);
      check({tag, " ready"}, 32'(ahb_ready_out), 32'd1);
      check("R10 resp okay on probe", 32'(ahb_resp), 32'd0);
      ahb_sel = 1'b0; ahb_trans = 2'b00; ext_wait = 1'b0;
      @(negedge clk); #1;
      check({tag, " still idle"}, 32'(apb_enable), 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : main
      logic [31:0] a, wbase;
      repeat (2) @(negedge clk);
      #1;
      check("R1 reset psel", 32'(apb_sel), 32'd0);
      check("R1 reset penable", 32'(apb_enable), 32'd0);
      check("R1 reset ready", 32'(ahb_ready_out), 32'd1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      check("R1 ready after reset", 32'(ahb_ready_out), 32'd1);

      // single beats over every window index and a foreign base (R7, R8)
      for (int r = 0; r < 5; r++) begin
         for (int wr = 0; wr < 2; wr++) begin
            a = (r < 4) ? (32'h2000_0000 + 32'(r) * 32'h1000 + 32'h10 + 32'(wr * 4))
                        : 32'h3000_0010;
            beat_addr[0] = a;
            run_beats(1, wr[0]);
         end
      end

      // incrementing bursts of 4 in each peripheral (R9)
      for (int p = 0; p < 3; p++) begin
         for (int wr = 0; wr < 2; wr++) begin
            for (int k = 0; k < 4; k++)
               beat_addr[k] = 32'h2000_0000 + 32'(p) * 32'h1000 + 32'h100 + 32'(k * 4);
            run_beats(4, wr[0]);
         end
      end

      // wrapping bursts of 4 and 8 beats starting mid-block (R9)
      for (int len = 4; len <= 8; len += 4) begin
         for (int wr = 0; wr < 2; wr++) begin
            a = 32'h2000_1038;
            wbase = a & ~(32'(len * 4) - 32'd1);
            for (int k = 0; k < len; k++)
               beat_addr[k] = wbase | ((a + 32'(k * 4)) & (32'(len * 4) - 32'd1));
            run_beats(len, wr[0]);
         end
      end

      // incrementing burst of 16 reads crossing into the unmatched window
      for (int k = 0; k < 16; k++) beat_addr[k] = 32'h2000_2FE0 + 32'(k * 4);
      run_beats(16, 1'b0);

      probe("R2 busy", 1'b1, 2'b01, 1'b0);
      probe("R2 idle trans", 1'b1, 2'b00, 1'b0);
      probe("R2 not selected", 1'b0, 2'b10, 1'b0);
      probe("R2 foreign wait", 1'b1, 2'b10, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule